// File: doc/BRIEF.md
# Serial Configuration Loader with Readback Check

This block loads a readout chip's two serial configuration registers. The global register is 231 bits long and the pixel register is 2880 bits long. The block shifts the bits out of an on-chip source memory, one bit per configuration clock pulse. After the last bit it raises a load strobe. On every rising edge of the configuration clock it also samples the chip's serial return line and stores that bit in a second, separate capture memory. Software can then read back what the chip held before the new contents replaced it.

Both memories have two ports. The host side moves one byte at a time. The shifter side reads the source memory, or writes the capture memory, one bit at a time. Each memory holds two complete configuration sets, and each set has one global image and one pixel image. A start command selects the register, the set and the clock divider. While the pass runs, the block compares every returned bit with the bit it drives at the same position. A shift-register chip returns its previous contents in the order they were loaded, so a flag records any difference from the image written in the previous pass.

A single state machine controls the sequence through five states. `IDLE` moves to `LOW` on start. `LOW` moves to `HIGH` when the low phase count expires. `HIGH` moves back to `LOW` when the high phase count expires and bits remain, or to `LOAD` after the last bit. `LOAD` moves to `DONE` after one full clock period. `DONE` always returns to `IDLE`.

Top module: `cfg_shifter`

## Requirements
- R1: A host write stores `host_wdata` at byte `host_addr` of the source memory. A host read returns the byte at `host_addr` on `host_rdata` one cycle later, taken from the source memory when `host_rsel`=0 and from the capture memory when `host_rsel`=1.
- R2: Register bit i of set s is stored at byte s*389 + (pixel ? 29 : 0) + i/8, at bit position i%8, in both memories. Bits are shifted out starting with bit 0 and in ascending order, one bit per configuration clock pulse, on `cfg_dout`.
- R3: With D = max(`clk_div`, 4) latched at start, each bit period is floor(D/2) cycles with `cfg_clk` low followed by D-floor(D/2) cycles with `cfg_clk` high. `cfg_dout` changes only while `cfg_clk` is low.
- R4: After the last high phase, `cfg_load` is high for exactly D cycles while `cfg_clk` stays low. `done` then pulses for one cycle, and the block is idle in the next cycle.
- R5: `cfg_din` is sampled in the cycle in which `cfg_clk` rises for bit i, and is written to the capture memory at the bit address of bit i for the same set and register.
- R6: `mismatch` clears when a start is accepted and is set for the rest of the pass if any sampled `cfg_din` differs from the bit driven for that position. While the block is idle, `mismatch` does not change.
- R7: A start while `busy` is high has no effect on the running pass: its bit count, data, timing and result are unchanged.
- R8: A pass produces exactly 231 configuration clock pulses when `reg_sel`=0 (global) and exactly 2880 pulses when `reg_sel`=1 (pixel).
- R9: After reset, `busy`, `done`, `cfg_clk`, `cfg_load`, `cfg_dout` and `mismatch` are all low, and they stay quiet until a start.
- R10: `set_sel` chooses which of the two stored sets is shifted out and which capture area receives the returned bits. The other set is left untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a pass when idle |
| reg_sel | input | 1 | 0 = global register, 1 = pixel register |
| set_sel | input | 1 | Configuration set to use |
| clk_div | input | 8 | System cycles per configuration clock period (4 minimum) |
| host_we | input | 1 | Host byte write to the source memory |
| host_addr | input | 10 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rsel | input | 1 | Read select: 0 = source memory, 1 = capture memory |
| host_rdata | output | 8 | Host read byte, one cycle latency |
| cfg_dout | output | 1 | Serial data to the chip |
| cfg_clk | output | 1 | Configuration clock to the chip |
| cfg_load | output | 1 | Load strobe to the chip |
| cfg_din | input | 1 | Serial readback from the chip |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| mismatch | output | 1 | Readback differed from driven data in the last pass |

## Verification
The checks assume that `start`, `cfg_din` and the host inputs are synchronous to `clk`. They also assume that the chip's return bit is stable across each rising configuration clock edge. The bench meets this with a behavioural shift-register chip that shifts on `cfg_clk` and drives its last stage onto `cfg_din`. The expected mismatch result assumes the host does not rewrite the source image of a register during its pass. The stimulus therefore writes memory only while `busy` is low. The one start issued mid-pass carries deliberately different selections and a different divider, so that any effect on the pass would show.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_LOAD,
        ST_DONE
    } cfg_state_t;

    function automatic int bytes_for(input int nbits);
        return (nbits + 7) / 8;
    endfunction

endpackage

// File: rtl/cfg_mem.sv
module cfg_mem #(
    parameter int BYTES = 778,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          h_we,
    input  logic [AW-1:0] h_addr,
    input  logic [7:0]    h_wdata,
    output logic [7:0]    h_rdata,
    input  logic          b_we,
    input  logic [AW-1:0] b_addr,
    input  logic [2:0]    b_sel,
    input  logic          b_wdata,
    output logic          b_rdata
);

    logic [7:0] mem [BYTES];

    logic h_ok;
    logic b_ok;
    assign h_ok = int'(h_addr) < BYTES;
    assign b_ok = int'(b_addr) < BYTES;

    always_ff @(posedge clk) begin
        if (b_we && b_ok) begin
            mem[b_addr][b_sel] <= b_wdata;
        end
        if (h_we && h_ok) begin
            mem[h_addr] <= h_wdata;
        end
        h_rdata <= h_ok ? mem[h_addr] : 8'h00;
    end

    assign b_rdata = b_ok ? mem[b_addr][b_sel] : 1'b0;

endmodule

// File: rtl/cfg_seq.sv
module cfg_seq
    import cfg_pkg::*;
#(
    parameter int GLB_BITS  = 231,
    parameter int PIX_BITS  = 2880,
    parameter int DIV_W     = 8,
    parameter int SET_W     = 1,
    parameter int SET_BYTES = 389,
    parameter int GLB_BYTES = 29,
    parameter int AW        = 10,
    parameter int IW        = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             reg_sel,
    input  logic [SET_W-1:0] set_sel,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             src_bit,
    input  logic             cfg_din,
    output logic [AW-1:0]    rd_addr,
    output logic [2:0]       rd_sel,
    output logic             cap_we,
    output logic [AW-1:0]    cap_addr,
    output logic [2:0]       cap_sel,
    output logic             cfg_dout,
    output logic             cfg_clk,
    output logic             cfg_load,
    output logic             busy,
    output logic             done,
    output logic             mismatch
);

    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(4);

    cfg_state_t       state, state_n;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;
    logic [IW-1:0]    idx;
    logic             reg_q;
    logic [SET_W-1:0] set_q;

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] lo_len;
    logic [DIV_W-1:0] hi_len;
    logic [IW-1:0]    last_idx;
    logic [IW-1:0]    nxt_idx;
    logic [AW-1:0]    base_q;
    logic             sample;

    function automatic logic [AW-1:0] region_base(input logic [SET_W-1:0] s, input logic r);
        return AW'(int'(s) * SET_BYTES + (r ? GLB_BYTES : 0));
    endfunction

    assign div_eff  = (clk_div < MIN_DIV) ? MIN_DIV : clk_div;
    assign lo_len   = div_q >> 1;
    assign hi_len   = div_q - lo_len;
    assign last_idx = reg_q ? IW'(PIX_BITS - 1) : IW'(GLB_BITS - 1);
    assign nxt_idx  = (idx == last_idx) ? idx : idx + 1'b1;
    assign base_q   = region_base(set_q, reg_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // next-state decode
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (start)                state_n = ST_LOW;
            ST_LOW:  if (cnt == lo_len - 1'b1) state_n = ST_HIGH;
            ST_HIGH: if (cnt == hi_len - 1'b1) state_n = (idx == last_idx) ? ST_LOAD : ST_LOW;
            ST_LOAD: if (cnt == div_q - 1'b1)  state_n = ST_DONE;
            ST_DONE:                           state_n = ST_IDLE;
            default:                           state_n = ST_IDLE;
        endcase
    end

    assign sample = (state == ST_LOW) && (state_n == ST_HIGH);

    // registered outputs and pass context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            div_q    <= MIN_DIV;
            idx      <= '0;
            reg_q    <= 1'b0;
            set_q    <= '0;
            cfg_dout <= 1'b0;
            mismatch <= 1'b0;
        end else begin
            cnt <= (state == ST_IDLE || state != state_n) ? '0 : cnt + 1'b1;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        div_q    <= div_eff;
                        reg_q    <= reg_sel;
                        set_q    <= set_sel;
                        idx      <= '0;
                        cfg_dout <= src_bit;
                        mismatch <= 1'b0;
                    end
                end
                ST_LOW: begin
                    if (sample && (cfg_din != cfg_dout)) begin
                        mismatch <= 1'b1;
                    end
                end
                ST_HIGH: begin
                    if (state_n == ST_LOW) begin
                        idx      <= nxt_idx;
                        cfg_dout <= src_bit;
                    end else if (state_n == ST_LOAD) begin
                        cfg_dout <= 1'b0;
                    end
                end
                ST_LOAD: ;
                ST_DONE: ;
                default: ;
            endcase
        end
    end

    // source read looks one bit ahead; capture write uses the current bit
    assign rd_addr  = (state == ST_IDLE) ? region_base(set_sel, reg_sel)
                                         : base_q + AW'(nxt_idx >> 3);
    assign rd_sel   = (state == ST_IDLE) ? 3'd0 : nxt_idx[2:0];
    assign cap_we   = sample;
    assign cap_addr = base_q + AW'(idx >> 3);
    assign cap_sel  = idx[2:0];

    assign cfg_clk  = (state == ST_HIGH);
    assign cfg_load = (state == ST_LOAD);
    assign busy     = (state != ST_IDLE);
    assign done     = (state == ST_DONE);

endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
    import cfg_pkg::*;
#(
    parameter int GLB_BITS = 231,
    parameter int PIX_BITS = 2880,
    parameter int NUM_SETS = 2,
    parameter int DIV_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             reg_sel,
    input  logic             set_sel,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             host_we,
    input  logic [9:0]       host_addr,
    input  logic [7:0]       host_wdata,
    input  logic             host_rsel,
    output logic [7:0]       host_rdata,
    output logic             cfg_dout,
    output logic             cfg_clk,
    output logic             cfg_load,
    input  logic             cfg_din,
    output logic             busy,
    output logic             done,
    output logic             mismatch
);

    localparam int GLB_BYTES = bytes_for(GLB_BITS);
    localparam int PIX_BYTES = bytes_for(PIX_BITS);
    localparam int SET_BYTES = GLB_BYTES + PIX_BYTES;
    localparam int MEM_BYTES = NUM_SETS * SET_BYTES;
    localparam int AW        = 10;
    localparam int SET_W     = 1;
    localparam int IW        = $clog2((PIX_BITS > GLB_BITS) ? PIX_BITS : GLB_BITS);

    logic [AW-1:0] rd_addr;
    logic [2:0]    rd_sel;
    logic          src_bit;
    logic          cap_we;
    logic [AW-1:0] cap_addr;
    logic [2:0]    cap_sel;
    logic [7:0]    src_hdata;
    logic [7:0]    cap_hdata;
    logic          cap_bit_unused;
    logic          rsel_q;

    cfg_seq #(
        .GLB_BITS (GLB_BITS),
        .PIX_BITS (PIX_BITS),
        .DIV_W    (DIV_W),
        .SET_W    (SET_W),
        .SET_BYTES(SET_BYTES),
        .GLB_BYTES(GLB_BYTES),
        .AW       (AW),
        .IW       (IW)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .reg_sel (reg_sel),
        .set_sel (set_sel),
        .clk_div (clk_div),
        .src_bit (src_bit),
        .cfg_din (cfg_din),
        .rd_addr (rd_addr),
        .rd_sel  (rd_sel),
        .cap_we  (cap_we),
        .cap_addr(cap_addr),
        .cap_sel (cap_sel),
        .cfg_dout(cfg_dout),
        .cfg_clk (cfg_clk),
        .cfg_load(cfg_load),
        .busy    (busy),
        .done    (done),
        .mismatch(mismatch)
    );

    cfg_mem #(.BYTES(MEM_BYTES), .AW(AW)) u_src_mem (
        .clk    (clk),
        .h_we   (host_we),
        .h_addr (host_addr),
        .h_wdata(host_wdata),
        .h_rdata(src_hdata),
        .b_we   (1'b0),
        .b_addr (rd_addr),
        .b_sel  (rd_sel),
        .b_wdata(1'b0),
        .b_rdata(src_bit)
    );

    cfg_mem #(.BYTES(MEM_BYTES), .AW(AW)) u_cap_mem (
        .clk    (clk),
        .h_we   (1'b0),
        .h_addr (host_addr),
        .h_wdata(8'h00),
        .h_rdata(cap_hdata),
        .b_we   (cap_we),
        .b_addr (cap_addr),
        .b_sel  (cap_sel),
        .b_wdata(cfg_din),
        .b_rdata(cap_bit_unused)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsel_q <= 1'b0;
        end else begin
            rsel_q <= host_rsel;
        end
    end

    assign host_rdata = rsel_q ? cap_hdata : src_hdata;

endmodule

// File: rtl/cfg_shift_chk.sv
module cfg_shift_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic busy,
    input logic done,
    input logic cfg_clk,
    input logic cfg_load,
    input logic cfg_dout,
    input logic mismatch
);

    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_run <= '0;
        end else if (cfg_clk) begin
            if (hi_run != 16'hFFFF) hi_run <= hi_run + 1'b1;
        end else begin
            hi_run <= '0;
        end
    end

    p_load_clk_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |-> !cfg_clk);

    p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_dout_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clk |-> $stable(cfg_dout));

    p_high_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_clk) |-> (hi_run >= 16'd2));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!cfg_clk && !cfg_load && !done));

    p_mismatch_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(mismatch));

    p_busy_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind cfg_shifter cfg_shift_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .cfg_clk (cfg_clk),
    .cfg_load(cfg_load),
    .cfg_dout(cfg_dout),
    .mismatch(mismatch)
);

// File: tb/test_cfg_shifter.sv
module test_cfg_shifter;

    localparam int GLB = 231;
    localparam int PIX = 2880;
    localparam int GLB_BY = 29;
    localparam int SET_BY = 389;
    localparam int MEM_BY = 778;

    typedef struct {
        int n;
        int d;
        bit m;
    } pass_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       reg_sel = 1'b0;
    logic       set_sel = 1'b0;
    logic [7:0] clk_div = 8'd4;
    logic       host_we = 1'b0;
    logic [9:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_rsel = 1'b0;
    logic [7:0] host_rdata;
    logic       cfg_dout, cfg_clk, cfg_load, cfg_din;
    logic       busy, done, mismatch;

    always #10 clk = ~clk;

    cfg_shifter i_cfg_shifter (
        .clk(clk), .rst_n(rst_n), .start(start), .reg_sel(reg_sel), .set_sel(set_sel),
        .clk_div(clk_div), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rsel(host_rsel), .host_rdata(host_rdata), .cfg_dout(cfg_dout), .cfg_clk(cfg_clk),
        .cfg_load(cfg_load), .cfg_din(cfg_din), .busy(busy), .done(done), .mismatch(mismatch)
    );

    // behavioural chip: two shift registers, last stage returned
    logic [GLB-1:0] chip_glb = '0;
    logic [PIX-1:0] chip_pix = '0;
    bit cur_reg = 1'b0;
    always @(posedge cfg_clk) begin
        if (cur_reg) chip_pix <= {chip_pix[PIX-2:0], cfg_dout};
        else         chip_glb <= {chip_glb[GLB-2:0], cfg_dout};
    end
    assign cfg_din = cur_reg ? chip_pix[PIX-1] : chip_glb[GLB-1];

    int total = 0;
    int bad = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // expected state kept by the bench
    logic [7:0] img [MEM_BY];
    bit exp_glb [GLB];
    bit exp_pix [PIX];
    bit    bitq[$];
    pass_t passq[$];
    int cur_d = 4;
    int passes_done = 0;

    // monitor
    bit prev_clk = 0, prev_load = 0, prev_done = 0;
    int lo_cnt = 0, hi_cnt = 0, ld_cnt = 0, pulses = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_clk && !prev_clk) begin
                chk(lo_cnt == cur_d / 2, "R3", "low phase length", lo_cnt, cur_d / 2);
                if (bitq.size() == 0) chk(0, "R2", "unexpected clock pulse", 1, 0);
                else begin
                    bit b;
                    b = bitq.pop_front();
                    chk(cfg_dout == b, "R2", "serial data bit", cfg_dout, b);
                end
                pulses++;
                lo_cnt = 0;
            end
            if (!cfg_clk && prev_clk) begin
                chk(hi_cnt == cur_d - cur_d / 2, "R3", "high phase length", hi_cnt, cur_d - cur_d / 2);
                hi_cnt = 0;
            end
            if (cfg_clk) hi_cnt++;
            if (busy && !cfg_clk && !cfg_load && !done) lo_cnt++;
            if (cfg_load) ld_cnt++;
            if (!cfg_load && prev_load) begin
                chk(ld_cnt == cur_d, "R4", "load strobe length", ld_cnt, cur_d);
                ld_cnt = 0;
            end
            if (prev_done) chk(!done && !busy, "R4", "done one cycle then idle", {done, busy}, 0);
            if (done) begin
                if (passq.size() == 0) chk(0, "R4", "unexpected done", 1, 0);
                else begin
                    pass_t p;
                    p = passq.pop_front();
                    chk(pulses == p.n, "R8", "clock pulse count", pulses, p.n);
                    chk(mismatch == p.m, "R6", "mismatch at done", mismatch, p.m);
                    chk(bitq.size() == 0, "R2", "bits left unshifted", bitq.size(), 0);
                end
                pulses = 0;
                lo_cnt = 0;
                passes_done++;
            end
            prev_clk = cfg_clk;
            prev_load = cfg_load;
            prev_done = done;
        end
    end

    task automatic host_write(input int a, input logic [7:0] v);
        @(negedge clk);
        host_we = 1'b1; host_addr = 10'(a); host_wdata = v;
        @(negedge clk);
        host_we = 1'b0;
        img[a] = v;
    endtask

    task automatic host_read(input int a, input bit sel, output logic [7:0] v);
        @(negedge clk);
        host_addr = 10'(a); host_rsel = sel;
        @(negedge clk);
        v = host_rdata;
    endtask

    // driver: push expectations, run one pass, check capture memory
    task automatic run_pass(input int s, input bit r, input int dv, input bit poke);
        int n, d, base, target;
        bit em;
        bit cap_exp [PIX];
        logic [7:0] got;
        n = r ? PIX : GLB;
        d = (dv < 4) ? 4 : dv;
        base = s * SET_BY + (r ? GLB_BY : 0);
        em = 0;
        for (int i = 0; i < n; i++) begin
            bit b, pv;
            b = img[base + i / 8][i % 8];
            pv = r ? exp_pix[i] : exp_glb[i];
            bitq.push_back(b);
            cap_exp[i] = pv;
            if (pv != b) em = 1;
        end
        passq.push_back('{n: n, d: d, m: em});
        cur_d = d;
        cur_reg = r;
        target = passes_done + 1;
        @(negedge clk);
        start = 1'b1; set_sel = s[0]; reg_sel = r; clk_div = 8'(dv);
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
        chk(mismatch == 1'b0, "R6", "mismatch cleared on start", mismatch, 0);
        if (poke) begin
            repeat (50) @(negedge clk);
            start = 1'b1; set_sel = ~s[0]; reg_sel = ~r; clk_div = 8'd9;
            repeat (3) @(negedge clk);
            start = 1'b0;
        end
        while (passes_done < target) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            if (r) exp_pix[i] = img[base + i / 8][i % 8];
            else   exp_glb[i] = img[base + i / 8][i % 8];
        end
        // R5: capture memory holds the returned bits at the same addresses
        for (int k = 0; k < (n + 7) / 8; k++) begin
            logic [7:0] ex, mk;
            ex = '0; mk = '0;
            for (int j = 0; j < 8; j++) begin
                if (k * 8 + j < n) begin
                    mk[j] = 1'b1;
                    ex[j] = cap_exp[k * 8 + j];
                end
            end
            host_read(base + k, 1'b1, got);
            chk((got & mk) == ex, "R5", "capture byte", int'(got & mk), int'(ex));
        end
        chk(mismatch == em, "R6", "mismatch held while idle", mismatch, em);
    endtask

    initial begin
        logic [7:0] v;
        for (int a = 0; a < MEM_BY; a++) img[a] = '0;
        for (int i = 0; i < GLB; i++) exp_glb[i] = 0;
        for (int i = 0; i < PIX; i++) exp_pix[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({busy, done, cfg_clk, cfg_load, cfg_dout, mismatch} == 6'b0, "R9", "reset outputs",
            {busy, done, cfg_clk, cfg_load, cfg_dout, mismatch}, 0);
        for (int a = 0; a < MEM_BY; a++) host_write(a, 8'((a * 73 + 29) ^ (a >> 3)));
        host_read(0, 1'b0, v);   chk(v == img[0],   "R1", "host read byte 0",   v, img[0]);
        host_read(28, 1'b0, v);  chk(v == img[28],  "R1", "host read byte 28",  v, img[28]);
        host_read(777, 1'b0, v); chk(v == img[777], "R1", "host read byte 777", v, img[777]);
        run_pass(0, 1'b0, 4, 1'b0);   // global set 0, first load
        run_pass(0, 1'b0, 5, 1'b1);   // same image again, start mid-pass ignored (R7)
        run_pass(1, 1'b1, 4, 1'b0);   // pixel set 1
        run_pass(1, 1'b0, 2, 1'b0);   // global set 1, divider raised to 4 (R10, R3)
        host_write(SET_BY + GLB_BY + 100, img[SET_BY + GLB_BY + 100] ^ 8'hFF);
        run_pass(1, 1'b1, 7, 1'b0);   // modified pixel image, odd divider
        run_pass(1, 1'b1, 4, 1'b0);   // unchanged pixel image
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            chk(0, "R4", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule